// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block decides where a small 8-bit processor goes next. It takes the current instruction word, the current program counter and the two source register values. It returns the program counter for the following instruction and a flag that is high when control moves anywhere other than the next sequential instruction. The block is purely combinational. It sits between the register-file read ports and the PC register.

Every signed comparison comes from a single internal subtraction of the two operands. For the forms that compare against zero, the second operand is forced to zero. The zero, sign and overflow flags of that difference select taken or not-taken. A taken conditional branch adds a sign-extended 4-bit offset to the PC. The absolute jumps load the PC from an 8-bit instruction constant or from a register. The halt opcode holds the PC where it is.

Top module: `branch_unit`

## Requirements
- R1: The opcode is instruction bits [15:10]. The relative offset is bits [3:0], read as a two's-complement value from -8 to +7. The absolute constant is bits [7:0]. Bits [9:8] have no effect on any output.
- R2: Opcodes 20, 21, 22, 23, 24 and 25 are taken when Rj, compared as a signed 8-bit value with Rk, is equal, not equal, less, less-or-equal, greater and greater-or-equal, respectively.
- R3: Opcodes 3, 26, 27, 28, 29 and 30 are taken when signed Rj is equal to zero, below zero, above zero, at most zero, at least zero and not zero, respectively. Rk has no effect on them.
- R4: Operand pairs whose difference overflows 8 bits still give the true signed ordering. Two examples are Rj=-128 with Rk=127, and Rj=127 with Rk=-1.
- R5: A taken conditional branch gives next PC = PC + offset, modulo 256, and raises taken.
- R6: A conditional branch that is not taken gives next PC = PC + 1, modulo 256, with taken low.
- R7: Opcode 31 gives next PC = the absolute constant, with taken high.
- R8: Opcode 32 gives next PC = Rj, with taken high.
- R9: Opcode 33 (halt) gives next PC = current PC, with taken low.
- R10: Every other opcode, including 0 to 2, 4 to 19 and 34 to 63, gives next PC = PC + 1, modulo 256, with taken low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Current instruction word |
| pc_i | input | 8 | Current program counter |
| rj_i | input | 8 | Value read for the first source register |
| rk_i | input | 8 | Value read for the second source register |
| next_pc_o | output | 8 | Program counter for the next instruction |
| taken_o | output | 1 | High for a taken branch or a jump |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, a 16-bit instruction and a 4-bit offset. At these sizes every signed operand pair from -128 to 127 can be reached. This includes the pairs whose difference overflows, which are the only cases where the sign of the difference and the true ordering disagree. PC values near 0 and 255 bring the wrap of both the +1 path and the negative-offset path within reach. Random opcodes across the full 6-bit range confirm that non-control opcodes and the unused register field leave the sequential path alone.

// File: rtl/branch_unit_pkg.sv
// Shared opcode values and decode types for the branch condition unit.
// Assumes the 6-bit opcode numbering of the host instruction set.
package branch_unit_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OP_BRZ   = 6'd3;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'd20;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'd21;
    localparam logic [OPC_W-1:0] OP_BLT   = 6'd22;
    localparam logic [OPC_W-1:0] OP_BLE   = 6'd23;
    localparam logic [OPC_W-1:0] OP_BGT   = 6'd24;
    localparam logic [OPC_W-1:0] OP_BGE   = 6'd25;
    localparam logic [OPC_W-1:0] OP_BLTZ  = 6'd26;
    localparam logic [OPC_W-1:0] OP_BGTZ  = 6'd27;
    localparam logic [OPC_W-1:0] OP_BLEZ  = 6'd28;
    localparam logic [OPC_W-1:0] OP_BGEZ  = 6'd29;
    localparam logic [OPC_W-1:0] OP_BNZ   = 6'd30;
    localparam logic [OPC_W-1:0] OP_JCON  = 6'd31;
    localparam logic [OPC_W-1:0] OP_JREG  = 6'd32;
    localparam logic [OPC_W-1:0] OP_HALT  = 6'd33;

    // Kind of control transfer selected by the opcode.
    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_COND,
        FLOW_JCONST,
        FLOW_JREG,
        FLOW_HALT
    } flow_e;

    // Relation tested on the flags of A - B.
    typedef enum logic [2:0] {
        REL_EQ,
        REL_NE,
        REL_LT,
        REL_LE,
        REL_GT,
        REL_GE
    } rel_e;

    typedef struct packed {
        flow_e flow;
        rel_e  rel;
        logic  vs_zero;
    } decode_t;

endpackage

// File: rtl/branch_decode.sv
// Opcode decoder: maps an opcode to a flow kind, a relation and whether
// the second operand is forced to zero. Assumes package opcode numbering.
module branch_decode
    import branch_unit_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic [OP_W-1:0] opcode_i,
    output decode_t         dec_o
);

    // Table lookup from opcode to decoded control fields.
    always_comb begin
        dec_o.flow    = FLOW_SEQ;
        dec_o.rel     = REL_EQ;
        dec_o.vs_zero = 1'b0;
        case (opcode_i)
            OP_BRZ:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_EQ; dec_o.vs_zero = 1'b1; end
            OP_BEQ:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_EQ; end
            OP_BNE:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_NE; end
            OP_BLT:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_LT; end
            OP_BLE:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_LE; end
            OP_BGT:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_GT; end
            OP_BGE:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_GE; end
            OP_BLTZ: begin dec_o.flow = FLOW_COND; dec_o.rel = REL_LT; dec_o.vs_zero = 1'b1; end
            OP_BGTZ: begin dec_o.flow = FLOW_COND; dec_o.rel = REL_GT; dec_o.vs_zero = 1'b1; end
            OP_BLEZ: begin dec_o.flow = FLOW_COND; dec_o.rel = REL_LE; dec_o.vs_zero = 1'b1; end
            OP_BGEZ: begin dec_o.flow = FLOW_COND; dec_o.rel = REL_GE; dec_o.vs_zero = 1'b1; end
            OP_BNZ:  begin dec_o.flow = FLOW_COND; dec_o.rel = REL_NE; dec_o.vs_zero = 1'b1; end
            OP_JCON: dec_o.flow = FLOW_JCONST;
            OP_JREG: dec_o.flow = FLOW_JREG;
            OP_HALT: dec_o.flow = FLOW_HALT;
            default: dec_o.flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/branch_compare.sv
// Compare unit: subtracts B from A, derives zero, sign and overflow
// flags, and resolves the requested signed relation from those flags only.
// Assumes two's-complement operands of DATA_W bits.
module branch_compare
    import branch_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  rel_e              rel_i,
    output logic              hit_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              flag_z;
    logic              flag_s;
    logic              flag_v;

    // Form the difference and its three status flags.
    always_comb begin
        diff   = a_i - b_i;
        flag_z = (diff == '0);
        flag_s = diff[MSB];
        flag_v = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
    end

    // Pick the relation outcome from the flags.
    always_comb begin
        case (rel_i)
            REL_EQ:  hit_o = flag_z;
            REL_NE:  hit_o = !flag_z;
            REL_LT:  hit_o = flag_s ^ flag_v;
            REL_LE:  hit_o = flag_z || (flag_s ^ flag_v);
            REL_GT:  hit_o = !flag_z && (flag_s == flag_v);
            REL_GE:  hit_o = (flag_s == flag_v);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_target.sv
// Target selector: builds the sequential, relative, absolute-constant,
// register and hold candidates and picks one by flow kind and outcome.
// Assumes PC arithmetic wraps modulo 2**PC_W.
module branch_target
    import branch_unit_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int OFFS_W = 4,
    parameter int CABS_W = 8
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   rj_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [CABS_W-1:0] cabs_i,
    input  flow_e             flow_i,
    input  logic              hit_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o
);

    logic [PC_W-1:0] offs_ext;
    logic [PC_W-1:0] abs_fit;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;

    // Widen or trim the absolute constant to the PC width.
    generate
        if (CABS_W >= PC_W) begin : g_abs_trim
            assign abs_fit = cabs_i[PC_W-1:0];
        end else begin : g_abs_pad
            assign abs_fit = {{(PC_W-CABS_W){1'b0}}, cabs_i};
        end
    endgenerate

    // Sign-extend the relative offset and form both adders.
    always_comb begin
        offs_ext = {{(PC_W-OFFS_W){offs_i[OFFS_W-1]}}, offs_i};
        seq_pc   = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
        rel_pc   = pc_i + offs_ext;
    end

    // Choose the next PC and the taken flag.
    always_comb begin
        next_pc_o = seq_pc;
        taken_o   = 1'b0;
        case (flow_i)
            FLOW_COND: begin
                next_pc_o = hit_i ? rel_pc : seq_pc;
                taken_o   = hit_i;
            end
            FLOW_JCONST: begin
                next_pc_o = abs_fit;
                taken_o   = 1'b1;
            end
            FLOW_JREG: begin
                next_pc_o = rj_i;
                taken_o   = 1'b1;
            end
            FLOW_HALT: next_pc_o = pc_i;
            default:   next_pc_o = seq_pc;
        endcase
    end

endmodule

// File: rtl/branch_unit.sv
// Branch condition and next-PC unit (top). Splits the instruction into
// opcode, offset and absolute constant, resolves the condition, and
// returns the next PC. Purely combinational; the register select fields
// are resolved upstream and only their values arrive here.
module branch_unit
    import branch_unit_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OP_W    = OPC_W,
    parameter int RSEL_W  = 2,
    parameter int OFFS_W  = 4,
    parameter int INSTR_W = OP_W + 3 * RSEL_W + OFFS_W
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  pc_i,
    input  logic [DATA_W-1:0]  rj_i,
    input  logic [DATA_W-1:0]  rk_i,
    output logic [DATA_W-1:0]  next_pc_o,
    output logic               taken_o
);

    localparam int OPC_LSB = INSTR_W - OP_W;
    localparam int DST_LSB = OPC_LSB - RSEL_W;
    localparam int CABS_W  = DST_LSB;

    logic [OP_W-1:0]   opcode;
    logic [OFFS_W-1:0] offs;
    logic [CABS_W-1:0] cabs;
    logic [DATA_W-1:0] cmp_b;
    logic              hit;
    logic              unused_dst;
    decode_t           dec;

    // Slice the instruction fields.
    always_comb begin
        opcode     = instr_i[INSTR_W-1:OPC_LSB];
        offs       = instr_i[OFFS_W-1:0];
        cabs       = instr_i[CABS_W-1:0];
        unused_dst = ^instr_i[OPC_LSB-1:DST_LSB];
    end

    // Second operand is zero for the compare-with-zero forms.
    always_comb begin
        cmp_b = dec.vs_zero ? '0 : rk_i;
    end

    branch_decode #(
        .OP_W (OP_W)
    ) u_dec (
        .opcode_i (opcode),
        .dec_o    (dec)
    );

    branch_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .a_i   (rj_i),
        .b_i   (cmp_b),
        .rel_i (dec.rel),
        .hit_o (hit)
    );

    branch_target #(
        .PC_W   (DATA_W),
        .OFFS_W (OFFS_W),
        .CABS_W (CABS_W)
    ) u_tgt (
        .pc_i      (pc_i),
        .rj_i      (rj_i),
        .offs_i    (offs),
        .cabs_i    (cabs),
        .flow_i    (dec.flow),
        .hit_i     (hit),
        .next_pc_o (next_pc_o),
        .taken_o   (taken_o)
    );

endmodule

// File: rtl/branch_unit_chk.sv
// Assertion checker for branch_unit, bound to every instance. Relates the
// ports directly; it never looks at internal signals.
module branch_unit_chk #(
    parameter int DATA_W  = 8,
    parameter int OP_W    = 6,
    parameter int OFFS_W  = 4,
    parameter int INSTR_W = 16
) (
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  pc_i,
    input logic [DATA_W-1:0]  rj_i,
    input logic [DATA_W-1:0]  rk_i,
    input logic [DATA_W-1:0]  next_pc_o,
    input logic               taken_o
);

    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] inc_pc;
    logic [DATA_W-1:0] rel_pc;
    logic              is_cond;

    // Reference quantities built straight from the ports.
    always_comb begin
        op      = instr_i[INSTR_W-1:INSTR_W-OP_W];
        inc_pc  = pc_i + 1'b1;
        rel_pc  = pc_i + DATA_W'($signed(instr_i[OFFS_W-1:0]));
        is_cond = (op == 6'd3) || ((op >= 6'd20) && (op <= 6'd30));
    end

    // Output relations checked once the inputs have settled.
    always_comb begin
        if (!$isunknown({instr_i, pc_i, rj_i, rk_i})) begin
            // R9
            halt_hold_chk: assert ((op != 6'd33) || (next_pc_o == pc_i && !taken_o));
            // R7
            jcon_target_chk: assert ((op != 6'd31) || (taken_o && next_pc_o == instr_i[DATA_W-1:0]));
            // R8
            jreg_target_chk: assert ((op != 6'd32) || (taken_o && next_pc_o == rj_i));
            // R2
            beq_outcome_chk: assert ((op != 6'd20) || (taken_o == (rj_i == rk_i)));
            // R3
            bltz_outcome_chk: assert ((op != 6'd26) || (taken_o == rj_i[DATA_W-1]));
            // R5
            rel_target_chk: assert (!(is_cond && taken_o) || (next_pc_o == rel_pc));
            // R6
            seq_target_chk: assert (taken_o || (op == 6'd33) || (next_pc_o == inc_pc));
        end
    end

endmodule

bind branch_unit branch_unit_chk #(
    .DATA_W  (DATA_W),
    .OP_W    (OP_W),
    .OFFS_W  (OFFS_W),
    .INSTR_W (INSTR_W)
) u_chk (
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .rj_i      (rj_i),
    .rk_i      (rk_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o)
);

// File: tb/branch_unit_test.sv
// Self-checking bench for branch_unit: directed corners plus seeded random
// instructions, compared against a signed-integer reference model.
module branch_unit_test;

    logic        clk;
    logic        rst_n;
    logic [15:0] instr;
    logic [7:0]  pc;
    logic [7:0]  rj;
    logic [7:0]  rk;
    logic [7:0]  next_pc;
    logic        taken;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    branch_unit uut (
        .instr_i   (instr),
        .pc_i      (pc),
        .rj_i      (rj),
        .rk_i      (rk),
        .next_pc_o (next_pc),
        .taken_o   (taken)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Reference: signed comparisons on plain integers.
    function automatic void model(input logic [15:0] ins, input logic [7:0] p,
                                  input logic [7:0] a, input logic [7:0] b,
                                  output logic [7:0] nx, output logic tk);
        int sa = $signed(a);
        int sb = $signed(b);
        int off = ins[3] ? int'(ins[3:0]) - 16 : int'(ins[3:0]);
        int op = int'(ins[15:10]);
        bit cond = 1;
        bit hit = 0;
        case (op)
            3:  hit = (sa == 0);
            20: hit = (sa == sb);
            21: hit = (sa != sb);
            22: hit = (sa < sb);
            23: hit = (sa <= sb);
            24: hit = (sa > sb);
            25: hit = (sa >= sb);
            26: hit = (sa < 0);
            27: hit = (sa > 0);
            28: hit = (sa <= 0);
            29: hit = (sa >= 0);
            30: hit = (sa != 0);
            default: cond = 0;
        endcase
        tk = 0;
        nx = 8'((int'(p) + 1) % 256);
        if (cond && hit) begin
            tk = 1;
            nx = 8'((int'(p) + off + 256) % 256);
        end else if (op == 31) begin
            tk = 1;
            nx = ins[7:0];
        end else if (op == 32) begin
            tk = 1;
            nx = a;
        end else if (op == 33) begin
            nx = p;
        end
    endfunction

    function automatic logic [15:0] mk(input int op, input int ri, input int js,
                                        input int ks, input int c4);
        return {6'(op), 2'(ri), 2'(js), 2'(ks), 4'(c4)};
    endfunction

    // Drive one instruction and compare both outputs mid-cycle.
    task automatic run(input logic [15:0] ins, input logic [7:0] p,
                       input logic [7:0] a, input logic [7:0] b, input string req);
        logic [7:0] ex_nx;
        logic       ex_tk;
        @(posedge clk);
        instr = ins; pc = p; rj = a; rk = b;
        @(negedge clk);
        model(ins, p, a, b, ex_nx, ex_tk);
        n_checks++;
        if (next_pc !== ex_nx || taken !== ex_tk) begin
            n_errors++;
            $display("FAIL %s op=%0d pc=%h rj=%h rk=%h: got next=%h taken=%b, expected next=%h taken=%b",
                     req, ins[15:10], p, a, b, next_pc, taken, ex_nx, ex_tk);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ins;
        void'($urandom(32'd20250417));
        rst_n = 1'b0;
        instr = '0; pc = '0; rj = '0; rk = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: no-op at PC 0 steps to 1 (R10)
        run(16'h0000, 8'h00, 8'h00, 8'h00, "R10");
        // R1: Ri bits ignored on jump-const and on a branch
        run(mk(31, 3, 1, 2, 5), 8'h10, 8'h00, 8'h00, "R1");
        run(mk(20, 2, 0, 0, 3), 8'h10, 8'h05, 8'h05, "R1");
        // R2: equal operands across the six relations
        for (int op = 20; op <= 25; op++) run(mk(op, 0, 1, 2, 2), 8'h40, 8'h7F, 8'h7F, "R2");
        // R4: overflowing differences
        for (int op = 22; op <= 25; op++) begin
            run(mk(op, 0, 1, 2, 4), 8'h40, 8'h80, 8'h7F, "R4");
            run(mk(op, 0, 1, 2, 4), 8'h40, 8'h7F, 8'hFF, "R4");
        end
        // R3: zero, most negative, +1 against the zero forms; Rk ignored
        for (int op = 26; op <= 30; op++) begin
            run(mk(op, 0, 1, 2, 6), 8'h20, 8'h00, 8'h80, "R3");
            run(mk(op, 0, 1, 2, 6), 8'h20, 8'h80, 8'h00, "R3");
            run(mk(op, 0, 1, 2, 6), 8'h20, 8'h01, 8'hFF, "R3");
        end
        run(mk(3, 0, 1, 2, 1), 8'h20, 8'h00, 8'h33, "R3");
        // R5: negative offset wraps below zero, positive wraps above 255
        run(mk(3, 0, 1, 2, 8), 8'h03, 8'h00, 8'h00, "R5");
        run(mk(30, 0, 1, 2, 7), 8'hFC, 8'h01, 8'h00, "R5");
        // R6: not-taken at 255 wraps to 0
        run(mk(21, 0, 1, 2, 7), 8'hFF, 8'h09, 8'h09, "R6");
        // R7, R8, R9
        run({6'd31, 2'd0, 8'hC7}, 8'h05, 8'h11, 8'h22, "R7");
        run(mk(32, 0, 1, 2, 0), 8'h05, 8'hE3, 8'h22, "R8");
        run(mk(33, 0, 1, 2, 0), 8'h9A, 8'h00, 8'h00, "R9");
        // R10: non-control opcodes just above and below the control range
        run(mk(34, 0, 0, 0, 0), 8'hFF, 8'h00, 8'h00, "R10");
        run(mk(19, 0, 0, 0, 0), 8'h7E, 8'h00, 8'h00, "R10");

        // Random mix: half control opcodes, half any opcode
        for (int i = 0; i < 4000; i++) begin
            int op;
            if (i % 2 == 0) begin
                op = int'($urandom_range(33, 19));
                if (op == 19) op = 3;
            end else begin
                op = int'($urandom_range(63, 0));
            end
            ins = {6'(op), 10'($urandom)};
            run(ins, 8'($urandom), 8'($urandom), (i % 7 == 0) ? 8'($urandom_range(255, 0)) & 8'h81 : 8'($urandom),
                (op >= 20 && op <= 25) ? "R2" : ((op == 3 || (op >= 26 && op <= 30)) ? "R3" :
                (op == 31) ? "R7" : (op == 32) ? "R8" : (op == 33) ? "R9" : "R10"));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule